// File: doc/BRIEF.md
# Interrupt Priority Daisy-Chain Node

This block is one link of a prioritized interrupt chain. Several internal event sources feed it request bits. The node merges them into a single open-drain, active-low interrupt line. An enable input comes from the neighbour of higher priority, and an enable output goes to the neighbour of lower priority. When the node has no pending request and no interrupt in service, the enable passes straight through the node, so lower nodes may compete.

An acknowledge cycle is recognised when the acknowledge input is low at the rising edge of the address strobe. A node that is pulling the interrupt line at that moment drops its enable output for the rest of the cycle. When the data strobe falls, the node looks at its enable input. Only a node that sees it high, and was pulling the line, answers. It sets the in-service bit of its highest-priority eligible source, drives a vector on the data bus while the data strobe stays low, and lets go of the interrupt line. Software can also grant an acknowledge with a one-cycle command pulse. A second command clears the highest-priority in-service bit. All inputs are sampled on the rising edge of the block clock.

Top module: `irq_dc_node`

## Requirements
- R1: After reset the interrupt line is released, no source is in service, the vector output reads 0 and is not driven, and the enable output equals the enable input.
- R2: The interrupt pull (`irq_pull` high) asserts one clock after the enable input is high and some source is eligible. A source i is eligible when its request is set and no in-service bit at index 0..i is set. The pull is released one clock after neither condition holds.
- R3: Outside an acknowledge cycle and with no in-service bit set, `ieo` equals `iei` in the same cycle, whether or not requests are pending.
- R4: With `intack_n` low at an `as_n` rising edge, a node pulling the line holds `ieo` low from the next clock until the acknowledge cycle ends at the `ds_n` rising edge.
- R5: At a `ds_n` falling edge inside an acknowledge cycle, a node that was pulling at cycle start and sees `iei` high grants the lowest-index eligible source (index 0 has the highest priority). It sets that source's in-service bit and loads `vec_out` with `VEC_BASE` bits [7:3] over the 3-bit source index (default base 0xA0, so source 3 gives 0xA3). It raises `vec_oe` while `ds_n` stays low and releases the line on the same clock.
- R6: If `iei` is low at that `ds_n` falling edge, the node does not respond: `vec_oe` stays low, `vec_out` and the in-service bits are unchanged.
- R7: An `as_n` rising edge with `intack_n` high starts no acknowledge cycle. A following `ds_n` fall neither drives the vector nor changes service state.
- R8: A one-cycle `sw_ack` pulse with `iei` high and an eligible source grants that source as in R5, loading `vec_out`, but never raises `vec_oe`.
- R9: While any in-service bit is set, `ieo` is low.
- R10: An in-service bit at index k masks requests from sources k and above. A request from a source below k still pulls the line, so service can nest.
- R11: A one-cycle `reset_ius` pulse clears only the lowest-index set in-service bit.
- R12: `irq_n` is driven to 0 whenever `irq_pull` is high and is left at high impedance otherwise.

Top module port list order is given below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 1 | Data strobe, active low |
| intack_n | input | 1 | Acknowledge indication, active low, sampled at `as_n` rise |
| iei | input | 1 | Enable in from the higher-priority neighbour |
| src_req | input | NSRC | Request bits, index 0 highest priority |
| sw_ack | input | 1 | Software acknowledge command, one-cycle pulse |
| reset_ius | input | 1 | Clear-highest-in-service command, one-cycle pulse |
| ieo | output | 1 | Enable out to the lower-priority neighbour |
| irq_n | output | 1 | Open-drain interrupt line, 0 or high impedance |
| irq_pull | output | 1 | High while the node pulls `irq_n` low |
| vec_out | output | VEC_W | Last granted vector |
| vec_oe | output | 1 | Data bus drive enable for `vec_out` |

## Verification
The grant logic is exercised with a single request, with two simultaneous requests of different priority, and with a request under an existing in-service bit. Together these separate a correct priority pick from a pick of the wrong end, and separate masking of the granted source from masking of all sources. The acknowledge handshake is run with the enable input dropped between strobes and also with a plain non-acknowledge strobe cycle, which separates sampling at the data-strobe fall from sampling at the address-strobe rise. Nested service, followed by single clear commands, shows whether the clear removes only the highest in-service bit or all of them.

// File: rtl/irq_dc_pkg.sv
package irq_dc_pkg;

    // Which kind of acknowledge, if any, grants a source this cycle
    typedef enum logic [1:0] {
        GRANT_NONE = 2'd0,
        GRANT_HW   = 2'd1,
        GRANT_SW   = 2'd2
    } grant_e;

    // Handshake control state of the node
    typedef struct packed {
        logic ack;   // inside a hardware acknowledge cycle
        logic pend;  // node was pulling the line when the cycle began
        logic resp;  // node answered this acknowledge cycle
        logic irq;   // node pulls the interrupt line
    } ctl_t;

    // Strobe history
    typedef struct packed {
        logic as_prev;
        logic ds_prev;
    } strobe_t;

endpackage

// File: rtl/irq_dc_edge.sv
module irq_dc_edge
    import irq_dc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic as_n,
    input  logic ds_n,
    output logic as_rise,
    output logic ds_fall,
    output logic ds_rise
);

    strobe_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.as_prev = as_n;
        st_d.ds_prev = ds_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{as_prev: 1'b1, ds_prev: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign as_rise = !st_q.as_prev && as_n;
    assign ds_fall = st_q.ds_prev && !ds_n;
    assign ds_rise = !st_q.ds_prev && ds_n;

endmodule

// File: rtl/irq_dc_prio.sv
module irq_dc_prio #(
    parameter int NSRC  = 6,
    parameter int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0]  req,
    input  logic [NSRC-1:0]  ius,
    output logic             elig_any,
    output logic [SRC_W-1:0] win_idx,
    output logic             ius_any,
    output logic [NSRC-1:0]  ius_top_oh
);

    logic [NSRC-1:0] blk;
    logic [NSRC-1:0] elig;

    // blk[i]: some in-service bit at index 0..i is set
    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_blk
            if (i == 0) begin : g_first
                assign blk[i] = ius[i];
                assign ius_top_oh[i] = ius[i];
            end else begin : g_rest
                assign blk[i] = blk[i-1] | ius[i];
                assign ius_top_oh[i] = ius[i] & ~blk[i-1];
            end
        end
    endgenerate

    assign elig     = req & ~blk;
    assign elig_any = |elig;
    assign ius_any  = blk[NSRC-1];

    // lowest index eligible source wins
    always_comb begin
        win_idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (elig[i]) begin
                win_idx = SRC_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_dc_node.sv
module irq_dc_node
    import irq_dc_pkg::*;
#(
    parameter int              NSRC     = 6,
    parameter int              VEC_W    = 8,
    parameter logic [VEC_W-1:0] VEC_BASE = 8'hA0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             as_n,
    input  logic             ds_n,
    input  logic             intack_n,
    input  logic             iei,
    input  logic [NSRC-1:0]  src_req,
    input  logic             sw_ack,
    input  logic             reset_ius,
    output logic             ieo,
    output wire              irq_n,
    output logic             irq_pull,
    output logic [VEC_W-1:0] vec_out,
    output logic             vec_oe
);

    localparam int SRC_W = (NSRC > 1) ? $clog2(NSRC) : 1;

    typedef struct packed {
        logic [NSRC-1:0]  ius;
        logic [VEC_W-1:0] vec;
        ctl_t             ctl;
    } node_st_t;

    node_st_t st_d, st_q;

    logic             as_rise, ds_fall, ds_rise;
    logic             elig_any_q, ius_any_q;
    logic [SRC_W-1:0] win_idx_q;
    logic [NSRC-1:0]  ius_top_oh_q;
    logic             elig_any_d, ius_any_d;
    logic [SRC_W-1:0] win_idx_d;
    logic [NSRC-1:0]  ius_top_oh_d;
    grant_e           grant;

    irq_dc_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .as_n    (as_n),
        .ds_n    (ds_n),
        .as_rise (as_rise),
        .ds_fall (ds_fall),
        .ds_rise (ds_rise)
    );

    // priority view of the present service state
    irq_dc_prio #(.NSRC(NSRC), .SRC_W(SRC_W)) u_prio_cur (
        .req        (src_req),
        .ius        (st_q.ius),
        .elig_any   (elig_any_q),
        .win_idx    (win_idx_q),
        .ius_any    (ius_any_q),
        .ius_top_oh (ius_top_oh_q)
    );

    // priority view of the next service state, used for the line request
    irq_dc_prio #(.NSRC(NSRC), .SRC_W(SRC_W)) u_prio_nxt (
        .req        (src_req),
        .ius        (st_d.ius),
        .elig_any   (elig_any_d),
        .win_idx    (win_idx_d),
        .ius_any    (ius_any_d),
        .ius_top_oh (ius_top_oh_d)
    );

    always_comb begin
        st_d  = st_q;
        grant = GRANT_NONE;

        // cycle framing
        if (as_rise) begin
            st_d.ctl.ack  = !intack_n;
            st_d.ctl.pend = !intack_n && st_q.ctl.irq;
            st_d.ctl.resp = 1'b0;
        end else if (ds_rise && st_q.ctl.ack) begin
            st_d.ctl.ack  = 1'b0;
            st_d.ctl.pend = 1'b0;
            st_d.ctl.resp = 1'b0;
        end

        // grant decision
        if (!as_rise && st_q.ctl.ack && ds_fall && iei && st_q.ctl.pend && elig_any_q) begin
            grant = GRANT_HW;
        end else if (sw_ack && iei && elig_any_q) begin
            grant = GRANT_SW;
        end

        if (reset_ius) begin
            st_d.ius = st_q.ius & ~ius_top_oh_q;
        end

        if (grant != GRANT_NONE) begin
            st_d.ius[win_idx_q] = 1'b1;
            st_d.vec = {VEC_BASE[VEC_W-1:SRC_W], win_idx_q};
        end

        if (grant == GRANT_HW) begin
            st_d.ctl.resp = 1'b1;
        end

        st_d.ctl.irq = iei && elig_any_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ieo      = iei && !ius_any_q && !(st_q.ctl.ack && st_q.ctl.pend);
    assign irq_pull = st_q.ctl.irq;
    assign irq_n    = st_q.ctl.irq ? 1'b0 : 1'bz;
    assign vec_out  = st_q.vec;
    assign vec_oe   = st_q.ctl.resp && !ds_n;

    // R9: any service bit blocks the chain below
    a_r9_ius_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (|st_q.ius) |-> !ieo);

    // R3: idle node passes the enable through
    a_r3_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.ius == '0) && !st_q.ctl.ack) |-> (ieo == iei));

    // R5: an answer always marks a new source in service
    a_r5_resp_marks: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ctl.resp) |-> (st_q.ius != $past(st_q.ius)));

    // R6: an answer needs the enable input high at the data strobe fall
    a_r6_resp_needs_iei: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ctl.resp) |-> ($past(iei) && !$past(ds_n)));

    // R2: the line is only pulled after the enable input was high
    a_r2_pull_needs_iei: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pull) |-> $past(iei));

    // R11: a clear command removes at most one service bit
    a_r11_clear_one: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_ius && !sw_ack && !ds_fall) |=>
            ($countones(st_q.ius) + 1 >= $countones($past(st_q.ius))));

    // R12: the open-drain line is low while pulled
    a_r12_line_low: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pull |-> (irq_n == 1'b0));

    // R8: the bus is never driven outside a data strobe
    a_r8_bus_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe |-> !ds_n);

endmodule

// File: tb/irq_dc_node_test.sv
`timescale 1ns/1ps
module irq_dc_node_test;

    localparam int NSRC = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            as_n = 1'b1;
    logic            ds_n = 1'b1;
    logic            intack_n = 1'b1;
    logic            iei = 1'b1;
    logic [NSRC-1:0] src_req = '0;
    logic            sw_ack = 1'b0;
    logic            reset_ius = 1'b0;
    logic            ieo;
    wire             irq_n;
    logic            irq_pull;
    logic [7:0]      vec_out;
    logic            vec_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    irq_dc_node uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .as_n      (as_n),
        .ds_n      (ds_n),
        .intack_n  (intack_n),
        .iei       (iei),
        .src_req   (src_req),
        .sw_ack    (sw_ack),
        .reset_ius (reset_ius),
        .ieo       (ieo),
        .irq_n     (irq_n),
        .irq_pull  (irq_pull),
        .vec_out   (vec_out),
        .vec_oe    (vec_oe)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_reset_ius();
        reset_ius = 1'b1; step(); reset_ius = 1'b0;
    endtask

    task automatic pulse_sw_ack();
        sw_ack = 1'b1; step(); sw_ack = 1'b0;
    endtask

    task automatic start_cycle(input logic ack_n);
        intack_n = ack_n;
        as_n = 1'b0; step();
        as_n = 1'b1; step();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R1 irq_pull", {7'd0, irq_pull}, 8'd0);
        chk("R1 vec_oe", {7'd0, vec_oe}, 8'd0);
        chk("R1 vec_out", vec_out, 8'h00);
        chk("R1 ieo", {7'd0, ieo}, 8'd1);
    endtask

    task automatic t_request();
        src_req = 6'b001000; step();
        chk("R2 pull on request", {7'd0, irq_pull}, 8'd1);
        chk("R12 line low", {7'd0, irq_n}, 8'd0);
        chk("R3 ieo with pending", {7'd0, ieo}, 8'd1);
        iei = 1'b0; step();
        chk("R2 release on iei low", {7'd0, irq_pull}, 8'd0);
        chk("R3 ieo follows iei", {7'd0, ieo}, 8'd0);
        iei = 1'b1; step();
        chk("R2 pull again", {7'd0, irq_pull}, 8'd1);
    endtask

    task automatic t_hw_ack();
        start_cycle(1'b0);
        chk("R4 ieo held low", {7'd0, ieo}, 8'd0);
        ds_n = 1'b0; step();
        chk("R5 vec_oe", {7'd0, vec_oe}, 8'd1);
        chk("R5 vector src3", vec_out, 8'hA3);
        chk("R5 line released", {7'd0, irq_pull}, 8'd0);
        ds_n = 1'b1; intack_n = 1'b1; step();
        chk("R5 bus released", {7'd0, vec_oe}, 8'd0);
        chk("R9 ieo low in service", {7'd0, ieo}, 8'd0);
    endtask

    task automatic t_nesting();
        src_req = 6'b010000; step();
        chk("R10 lower masked", {7'd0, irq_pull}, 8'd0);
        src_req = 6'b010010; step();
        chk("R10 higher nests", {7'd0, irq_pull}, 8'd1);
        src_req = '0; step();
        pulse_reset_ius();
        chk("R11 cleared single", {7'd0, ieo}, 8'd1);
        src_req = 6'b010000; step();
        chk("R10 unmasked after clear", {7'd0, irq_pull}, 8'd1);
        src_req = '0; step();
    endtask

    task automatic t_hw_prio();
        src_req = 6'b010100; step();
        start_cycle(1'b0);
        ds_n = 1'b0; step();
        chk("R5 picks src2 over src4", vec_out, 8'hA2);
        ds_n = 1'b1; intack_n = 1'b1; step();
        src_req = '0;
        pulse_reset_ius();
        chk("R3 idle after clear", {7'd0, ieo}, 8'd1);
    endtask

    task automatic t_sw_ack();
        src_req = 6'b100100; step();
        pulse_sw_ack();
        chk("R8 vector src2", vec_out, 8'hA2);
        chk("R8 bus not driven", {7'd0, vec_oe}, 8'd0);
        chk("R8 ieo low", {7'd0, ieo}, 8'd0);
        chk("R10 src5 masked", {7'd0, irq_pull}, 8'd0);
        src_req = '0; step();
    endtask

    task automatic t_reset_highest();
        // src2 in service from the previous task
        src_req = 6'b000001; step();
        chk("R10 src0 over ius2", {7'd0, irq_pull}, 8'd1);
        pulse_sw_ack();
        chk("R8 vector src0", vec_out, 8'hA0);
        src_req = '0; step();
        pulse_reset_ius();
        chk("R11 src2 stays", {7'd0, ieo}, 8'd0);
        src_req = 6'b000010; step();
        chk("R11 src0 cleared", {7'd0, irq_pull}, 8'd1);
        src_req = 6'b001000; step();
        chk("R11 src3 still masked", {7'd0, irq_pull}, 8'd0);
        src_req = '0; step();
        pulse_reset_ius();
        chk("R11 second clear", {7'd0, ieo}, 8'd1);
    endtask

    task automatic t_iei_drop();
        src_req = 6'b000010; step();
        start_cycle(1'b0);
        iei = 1'b0; step();
        ds_n = 1'b0; step();
        chk("R6 no bus drive", {7'd0, vec_oe}, 8'd0);
        chk("R6 vector kept", vec_out, 8'hA0);
        ds_n = 1'b1; intack_n = 1'b1; step();
        iei = 1'b1; step();
        chk("R6 no service set", {7'd0, ieo}, 8'd1);
        chk("R6 still requesting", {7'd0, irq_pull}, 8'd1);
        src_req = '0; step();
    endtask

    task automatic t_not_ack();
        src_req = 6'b010000; step();
        start_cycle(1'b1);
        chk("R7 ieo passes", {7'd0, ieo}, 8'd1);
        ds_n = 1'b0; step();
        chk("R7 no bus drive", {7'd0, vec_oe}, 8'd0);
        chk("R7 still requesting", {7'd0, irq_pull}, 8'd1);
        ds_n = 1'b1; step();
        chk("R7 no service set", {7'd0, ieo}, 8'd1);
        src_req = '0; step();
    endtask

    initial begin
        t_reset();
        t_request();
        t_hw_ack();
        t_nesting();
        t_hw_prio();
        t_sw_ack();
        t_reset_highest();
        t_iei_drop();
        t_not_ack();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule